// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional

This block keeps track of a single atomic reservation for a 32-bit core. It watches two streams at once: a load port, where a load can be marked as reserving, and a store port, where a store is either ordinary or conditional. When a reserving load is seen, the block remembers that a reservation is open and records the load's full effective address. When a conditional store arrives, the block decides in the same cycle whether that store may write memory. It compares the store address with the recorded one and requires the reservation to be open. In the following cycle it presents the outcome as a success flag meant for the core's status register.

A reservation is closed in three ways. Any conditional store closes it, whether it succeeds or fails. An ordinary store of any size closes it when the store lands in the reserved 32-bit word. A flush input, driven by an exception return or a pipeline flush, also closes it. Reserving loads and conditional stores are always word accesses.

The control is a two-state machine. RSV_EMPTY means no reservation is open. RSV_HELD means one is open. The transitions are named as follows:
- T_ACQUIRE goes from RSV_EMPTY to RSV_HELD on a reserving load.
- T_RENEW stays in RSV_HELD and replaces the address when another reserving load arrives.
- T_CONSUME goes from RSV_HELD to RSV_EMPTY on a conditional store.
- T_SNOOP_KILL goes from RSV_HELD to RSV_EMPTY on an ordinary store to the reserved word.
- T_FLUSH goes from either state to RSV_EMPTY on flush.

Top module: `lrsc_monitor`

## Requirements
- R1: While reset is held (rst_n low) and in the first cycle after it, resv_valid is 0, resv_addr is 0 and sc_flag is 0.
- R2: A load with ld_valid=1 and ld_reserve=1 makes resv_valid 1 from the next cycle on, with resv_addr equal to that load's full ld_addr. A load with ld_reserve=0 changes neither output.
- R3: In the cycle after a conditional store (st_valid=1, st_cond=1), sc_flag is 1 if resv_valid was 1 and st_addr equalled resv_addr in all 32 bits when the store was presented. Otherwise sc_flag is 0.
- R4: st_write_en is combinational. For a conditional store it equals the success condition of R3 in the same cycle. For an ordinary store (st_cond=0) it is 1. Without st_valid it is 0.
- R5: Every conditional store makes resv_valid 0 in the next cycle, whether it succeeds or fails, unless R7 or R8 applies.
- R6: An ordinary store clears resv_valid in the next cycle when st_addr[31:2] equals resv_addr[31:2], whatever the values of bits 1:0. An ordinary store to any other word leaves the reservation untouched.
- R7: When a reserving load and a store arrive in the same cycle, the store is judged against the old reservation and the new reservation is kept afterwards.
- R8: flush=1 makes resv_valid 0 in the next cycle and takes priority over a reserving load in the same cycle. It does not change sc_flag.
- R9: sc_flag keeps its value in every cycle without a conditional store.
- R10: A conditional store to the reserved word at a different byte offset (st_addr bits 1:0 differ) fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_reserve | input | 1 | The presented load is a reserving load |
| ld_addr | input | 32 | Effective address of the load |
| st_valid | input | 1 | A store is presented this cycle |
| st_cond | input | 1 | The presented store is conditional |
| st_addr | input | 32 | Effective address of the store |
| flush | input | 1 | Exception return or flush: drop the reservation |
| st_write_en | output | 1 | The presented store may write memory |
| sc_flag | output | 1 | Outcome of the last conditional store |
| resv_valid | output | 1 | A reservation is open |
| resv_addr | output | 32 | Recorded reservation address |

## Verification
Conditional stores are exercised in four situations: with no reservation, with an exact address match, with a different word, and with the right word at a wrong byte offset. These cases separate the full-address comparison from the word-masked one. Ordinary stores are aimed both inside and outside the reserved word, which shows that only the word number matters when a reservation is snooped away. Same-cycle pairs of a reserving load with a store, and of flush with a reserving load, pin down the priority order. Runs of loads and ordinary stores after a successful conditional store show that the success flag holds its value.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [0:0] {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;
endpackage

// File: rtl/lrsc_match.sv
module lrsc_match #(
    parameter int ADDR_W     = 32,
    parameter int IGNORE_LSB = 0
) (
    input  logic [ADDR_W-1:0] lhs,
    input  logic [ADDR_W-1:0] rhs,
    output logic              same
);
    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((64'd1 << IGNORE_LSB) - 64'd1);
    localparam logic [ADDR_W-1:0] KEEP     = ~LOW_ONES;

    always_comb begin
        same = ((lhs ^ rhs) & KEEP) == '0;
    end
endmodule

// File: rtl/lrsc_fsm.sv
module lrsc_fsm
    import lrsc_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              acquire,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic              drop,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_addr
);
    rsv_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RSV_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // transitions: flush first, then acquire/renew, then drop
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        unique case (state_q)
            RSV_EMPTY: begin
                if (!flush && acquire) begin      // T_ACQUIRE
                    state_d = RSV_HELD;
                    addr_d  = acq_addr;
                end
            end
            RSV_HELD: begin
                if (flush) begin                  // T_FLUSH
                    state_d = RSV_EMPTY;
                end else if (acquire) begin       // T_RENEW
                    addr_d  = acq_addr;
                end else if (drop) begin          // T_CONSUME / T_SNOOP_KILL
                    state_d = RSV_EMPTY;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        resv_valid = (state_q == RSV_HELD);
        resv_addr  = addr_q;
    end

    assert_flush_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !resv_valid);

    assert_acquire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acquire && !flush) |=> (resv_valid && resv_addr == $past(acq_addr)));

    assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !acquire) |=> !resv_valid);
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_reserve,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic              st_cond,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              flush,
    output logic              st_write_en,
    output logic              sc_flag,
    output logic              resv_valid,
    output logic [ADDR_W-1:0] resv_addr
);
    localparam int OFFS_W = $clog2(WORD_BYTES);

    logic exact_hit, word_hit;
    logic lr_fire, sc_fire, plain_fire;
    logic sc_ok, kill;

    lrsc_match #(.ADDR_W(ADDR_W), .IGNORE_LSB(0)) u_exact (
        .lhs(st_addr), .rhs(resv_addr), .same(exact_hit));

    lrsc_match #(.ADDR_W(ADDR_W), .IGNORE_LSB(OFFS_W)) u_word (
        .lhs(st_addr), .rhs(resv_addr), .same(word_hit));

    always_comb begin
        lr_fire     = ld_valid && ld_reserve;
        sc_fire     = st_valid && st_cond;
        plain_fire  = st_valid && !st_cond;
        sc_ok       = sc_fire && resv_valid && exact_hit;
        kill        = sc_fire || (plain_fire && word_hit);
        st_write_en = plain_fire || sc_ok;
    end

    lrsc_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .acquire   (lr_fire),
        .acq_addr  (ld_addr),
        .drop      (kill),
        .resv_valid(resv_valid),
        .resv_addr (resv_addr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       sc_flag <= 1'b0;
        else if (sc_fire) sc_flag <= sc_ok;
    end

    assert_sc_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_cond && !resv_valid) |-> !st_write_en);

    assert_plain_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_cond) |-> st_write_en);

    assert_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_cond) |=> (sc_flag == $past(st_write_en)));

    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_valid && st_cond) |=> $stable(sc_flag));

    assert_sc_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_cond && !(ld_valid && ld_reserve)) |=> !resv_valid);
endmodule

// File: tb/test_lrsc_monitor.sv
module test_lrsc_monitor;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0, ld_reserve = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        st_valid = 1'b0, st_cond = 1'b0;
    logic [31:0] st_addr = '0;
    logic        flush = 1'b0;
    logic        st_write_en, sc_flag, resv_valid;
    logic [31:0] resv_addr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic        we;
        logic        valid;
        logic [31:0] addr;
        logic        flag;
    } item_t;
    item_t q[$];

    logic        m_valid = 1'b0;
    logic [31:0] m_addr = '0;
    logic        m_flag = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    lrsc_monitor i_lrsc_monitor (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_reserve(ld_reserve), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_cond(st_cond), .st_addr(st_addr),
        .flush(flush),
        .st_write_en(st_write_en), .sc_flag(sc_flag),
        .resv_valid(resv_valid), .resv_addr(resv_addr)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, push expected values for it
    task automatic op(string tag, logic lv, logic lr, logic [31:0] la,
                      logic sv, logic sc, logic [31:0] sa, logic fl);
        item_t it;
        logic hit, kill;
        @(posedge clk); #1;
        ld_valid = lv; ld_reserve = lr; ld_addr = la;
        st_valid = sv; st_cond = sc; st_addr = sa; flush = fl;
        hit  = m_valid && (sa == m_addr);
        it.tag = tag; it.valid = m_valid; it.addr = m_addr; it.flag = m_flag;
        it.we  = sv ? (sc ? hit : 1'b1) : 1'b0;
        q.push_back(it);
        kill = sv && (sc || (sa[31:2] == m_addr[31:2]));
        if (sv && sc) m_flag = hit;
        if (fl) m_valid = 1'b0;
        else if (lv && lr) begin m_valid = 1'b1; m_addr = la; end
        else if (kill) m_valid = 1'b0;
    endtask

    task automatic idle(string tag);
        op(tag, 0, 0, 32'h0, 0, 0, 32'h0, 0);
    endtask

    // monitor: compare at mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                chk(it.tag, "st_write_en", {31'b0, st_write_en}, {31'b0, it.we});
                chk(it.tag, "resv_valid", {31'b0, resv_valid}, {31'b0, it.valid});
                chk(it.tag, "resv_addr", resv_addr, it.addr);
                chk(it.tag, "sc_flag", {31'b0, sc_flag}, {31'b0, it.flag});
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "resv_valid", {31'b0, resv_valid}, 32'd0);
        chk("R1", "resv_addr", resv_addr, 32'd0);
        chk("R1", "sc_flag", {31'b0, sc_flag}, 32'd0);
        rst_n = 1'b1;
        idle("R1 after reset");
        op("R3 R4 R5 sc without reservation", 0, 0, 0, 1, 1, 32'h100, 0);
        op("R2 plain load", 1, 0, 32'h100, 0, 0, 0, 0);
        idle("R2 no reservation");
        op("R2 acquire", 1, 1, 32'h100, 0, 0, 0, 0);
        op("R6 R4 plain store other word", 0, 0, 0, 1, 0, 32'h204, 0);
        op("R3 R5 sc success", 0, 0, 0, 1, 1, 32'h100, 0);
        op("R9 plain store keeps flag", 0, 0, 0, 1, 0, 32'h100, 0);
        op("R9 load keeps flag", 1, 0, 32'h40, 0, 0, 0, 0);
        op("R3 sc after consume fails", 0, 0, 0, 1, 1, 32'h100, 0);
        op("R2 acquire 200", 1, 1, 32'h200, 0, 0, 0, 0);
        op("R6 byte store same word", 0, 0, 0, 1, 0, 32'h203, 0);
        op("R6 cleared", 0, 0, 0, 1, 1, 32'h200, 0);
        op("R2 acquire 300", 1, 1, 32'h300, 0, 0, 0, 0);
        op("R5 sc other word fails", 0, 0, 0, 1, 1, 32'h304, 0);
        op("R5 reservation gone", 0, 0, 0, 1, 1, 32'h300, 0);
        op("R2 acquire 400", 1, 1, 32'h400, 0, 0, 0, 0);
        op("R10 sc wrong byte", 0, 0, 0, 1, 1, 32'h401, 0);
        op("R2 acquire 500", 1, 1, 32'h500, 0, 0, 0, 0);
        op("R2 renew 600", 1, 1, 32'h600, 0, 0, 0, 0);
        op("R2 sc old addr fails", 0, 0, 0, 1, 1, 32'h500, 0);
        op("R7 lr with plain store same word", 1, 1, 32'h700, 1, 0, 32'h700, 0);
        op("R7 kept", 0, 0, 0, 1, 1, 32'h700, 0);
        op("R2 acquire 800", 1, 1, 32'h800, 0, 0, 0, 0);
        op("R7 lr with sc old reservation", 1, 1, 32'hA00, 1, 1, 32'h800, 0);
        op("R7 new reservation kept", 0, 0, 0, 0, 0, 0, 0);
        op("R2 acquire B00", 1, 1, 32'hB00, 0, 0, 0, 0);
        op("R8 flush", 0, 0, 0, 0, 0, 0, 1);
        op("R8 flag unaffected", 0, 0, 0, 1, 1, 32'hB00, 0);
        op("R8 flush with lr", 1, 1, 32'hC00, 0, 0, 0, 1);
        op("R8 flush wins", 0, 0, 0, 1, 1, 32'hC00, 0);
        idle("final");
        idle("final");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule